// File: doc/BRIEF.md
# Branch Target Buffer with Misprediction Recovery

This block is a direct-mapped cache of taken branches that sits beside the instruction fetch stage. The fetch PC is presented on the lookup port in the same cycle the instruction memory is read. If a valid entry whose tag matches is found, the block reports a hit, predicts taken and returns the stored target as the next fetch address. Otherwise it returns the sequential address, PC + 4.

Once a branch has resolved later in the pipeline, its outcome is presented on the resolve port. The block reads its own entry for that PC a second time and chooses one recovery action from the hit or miss state and the real outcome. The actions are: confirm the entry, rewrite its target, delete it, or allocate a new one. The last three also raise a kill with a corrected fetch PC, so the pipeline can flush the instructions it fetched down the wrong path. Writes land at the next clock edge.

Each entry holds a valid bit, a 20-bit tag, a 32-bit target and a 2-bit confidence counter. There are 1024 entries, indexed by PC bits 11..2. A new entry starts at weakly taken (2'b10). Each confirmed taken hit raises the counter until it saturates at 2'b11. Instruction memory and decode are outside this block.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset no entry is valid: every lookup gives lk_hit=0, lk_taken=0 and lk_next_pc=lk_pc+4.
- R2: An entry is selected by lk_pc[11:2] and matched against lk_pc[31:12]. Bits [1:0] of the PC take no part in the match.
- R3: On a resolve that misses and reports a taken branch, rs_kill=1 and rs_redirect_pc=rs_target in the same cycle. From the next cycle a lookup of that PC gives lk_hit=1, lk_taken=1 and lk_next_pc=rs_target.
- R4: On a resolve that misses and reports a non-branch or a not-taken branch, rs_kill=0 and no entry is written.
- R5: On a resolve that hits and reports a taken branch whose target equals the stored one, rs_kill=0 and the entry stays valid with the same target.
- R6: On a resolve that hits and reports a not-taken branch or a non-branch, rs_kill=1 and rs_redirect_pc=rs_pc+4. The entry is deleted, so later lookups of that PC miss.
- R7: On a resolve that hits and reports a taken branch to a different target, rs_kill=1 and rs_redirect_pc=rs_target. The entry's target is replaced with the new one.
- R8: Two PCs with the same index and different tags do not alias: a lookup of one misses while the other is stored. Allocating the second overwrites the first.
- R9: A resolve write takes effect at the clock edge. A lookup of the same entry in the same cycle returns the old contents.
- R10: While rs_valid=0, rs_kill=0 and nothing is written, whatever the other resolve inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_taken | output | 1 | Predict taken for this fetch |
| lk_next_pc | output | 32 | Next fetch address: stored target if predicted taken, else lk_pc+4 |
| rs_valid | input | 1 | A resolved instruction is presented |
| rs_pc | input | 32 | PC of the resolved instruction |
| rs_is_branch | input | 1 | The resolved instruction is a branch |
| rs_taken | input | 1 | The branch was taken |
| rs_target | input | 32 | Actual branch target |
| rs_kill | output | 1 | Flush instructions fetched after rs_pc |
| rs_redirect_pc | output | 32 | Corrected fetch PC, meaningful when rs_kill=1 |

## Verification
The resolve port is driven through every cell of hit or miss crossed with non-branch, not-taken, taken to the stored target and taken elsewhere. This tells the four recovery actions apart by their kill, their redirect address and the lookup result that follows. A pair of PCs that share an index but differ in tag separates tag matching from index selection. PCs that differ only in their low two bits show those bits are ignored. A lookup made in the same cycle as a write to its entry shows the old contents are returned until the edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = 10;
  localparam int unsigned CTR_W  = 2;
  localparam int unsigned OFS_W  = 2;
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_WEAK = {1'b1, {(CTR_W-1){1'b0}}};

  typedef struct packed {
    logic              valid;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] target;
    logic [CTR_W-1:0]  ctr;
  } btb_entry_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CONFIRM,
    ACT_RETARGET,
    ACT_DELETE,
    ACT_ALLOC
  } btb_action_e;
endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output btb_entry_t       rd_a,
  input  logic [IDX_W-1:0] rd_b_idx,
  output btb_entry_t       rd_b,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  btb_entry_t       wr_ent
);
  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q    [DEPTH];
  logic [ADDR_W-1:0] target_q [DEPTH];
  logic [CTR_W-1:0]  ctr_q    [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (we) begin
      valid_q[wr_idx] <= wr_ent.valid;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[wr_idx]    <= wr_ent.tag;
      target_q[wr_idx] <= wr_ent.target;
      ctr_q[wr_idx]    <= wr_ent.ctr;
    end
  end

  always_comb begin
    rd_a = '{valid: valid_q[rd_a_idx], tag: tag_q[rd_a_idx],
             target: target_q[rd_a_idx], ctr: ctr_q[rd_a_idx]};
    rd_b = '{valid: valid_q[rd_b_idx], tag: tag_q[rd_b_idx],
             target: target_q[rd_b_idx], ctr: ctr_q[rd_b_idx]};
  end

  // R9: a write is visible from the next cycle on
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (valid_q[$past(wr_idx)] == $past(wr_ent.valid)));
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  btb_entry_t        ent,
  output logic [IDX_W-1:0]  idx,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] seq_pc;

  always_comb begin
    idx     = pc[OFS_W +: IDX_W];
    tag     = pc[ADDR_W-1 -: TAG_W];
    seq_pc  = pc + ADDR_W'(4);
    hit     = ent.valid && (ent.tag == tag);
    taken   = hit && ent.ctr[CTR_W-1];
    next_pc = taken ? ent.target : seq_pc;
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_is_branch,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  input  btb_entry_t        ent,
  output logic [IDX_W-1:0]  idx,
  output logic              kill,
  output logic [ADDR_W-1:0] redirect_pc,
  output logic              we,
  output btb_entry_t        wr_ent
);
  logic [TAG_W-1:0]  tag;
  logic [ADDR_W-1:0] seq_pc;
  logic              hit;
  logic              went_taken;
  logic [CTR_W-1:0]  ctr_up;
  btb_action_e       act;

  always_comb begin
    idx        = rs_pc[OFS_W +: IDX_W];
    tag        = rs_pc[ADDR_W-1 -: TAG_W];
    seq_pc     = rs_pc + ADDR_W'(4);
    hit        = ent.valid && (ent.tag == tag);
    went_taken = rs_is_branch && rs_taken;
    ctr_up     = (&ent.ctr) ? ent.ctr : ent.ctr + CTR_W'(1);

    act = ACT_NONE;
    if (rs_valid) begin
      if (hit) begin
        if (!went_taken)                 act = ACT_DELETE;
        else if (ent.target != rs_target) act = ACT_RETARGET;
        else                             act = ACT_CONFIRM;
      end else if (went_taken) begin
        act = ACT_ALLOC;
      end
    end

    kill        = (act == ACT_DELETE) || (act == ACT_RETARGET) || (act == ACT_ALLOC);
    redirect_pc = went_taken ? rs_target : seq_pc;
    we          = (act != ACT_NONE);
    wr_ent.valid  = (act != ACT_DELETE);
    wr_ent.tag    = tag;
    wr_ent.target = rs_target;
    wr_ent.ctr    = (act == ACT_CONFIRM) ? ctr_up : CTR_WEAK;
  end

  // R10: no kill without a resolve
  a_r10_kill_needs_resolve: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> rs_valid);

  // R5: a taken branch passes without kill only if the stored target agreed
  a_r5_quiet_taken_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_is_branch && rs_taken && !kill) |-> (ent.valid && ent.target == rs_target));

  // R3: a fresh allocation always comes with a kill
  a_r3_alloc_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_ent.valid && !(ent.valid && ent.tag == rs_pc[ADDR_W-1 -: TAG_W])) |-> kill);
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_next_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_is_branch,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  output logic              rs_kill,
  output logic [ADDR_W-1:0] rs_redirect_pc
);
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] rs_idx;
  btb_entry_t       lk_ent;
  btb_entry_t       rs_ent;
  logic             wr_en;
  btb_entry_t       wr_ent;

  btb_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (lk_idx),
    .rd_a     (lk_ent),
    .rd_b_idx (rs_idx),
    .rd_b     (rs_ent),
    .we       (wr_en),
    .wr_idx   (rs_idx),
    .wr_ent   (wr_ent)
  );

  btb_lookup u_lookup (
    .pc      (lk_pc),
    .ent     (lk_ent),
    .idx     (lk_idx),
    .hit     (lk_hit),
    .taken   (lk_taken),
    .next_pc (lk_next_pc)
  );

  btb_resolve u_resolve (
    .clk          (clk),
    .rst_n        (rst_n),
    .rs_valid     (rs_valid),
    .rs_pc        (rs_pc),
    .rs_is_branch (rs_is_branch),
    .rs_taken     (rs_taken),
    .rs_target    (rs_target),
    .ent          (rs_ent),
    .idx          (rs_idx),
    .kill         (rs_kill),
    .redirect_pc  (rs_redirect_pc),
    .we           (wr_en),
    .wr_ent       (wr_ent)
  );

  // R6: a hit on a non-taken outcome clears the entry at the edge
  a_r6_delete_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_kill && !(rs_is_branch && rs_taken)) |=> !u_store.valid_q[$past(rs_idx)]);
endmodule

// File: tb/branch_target_buffer_test.sv
module branch_target_buffer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_next_pc;
  logic        rs_valid, rs_is_branch, rs_taken;
  logic [31:0] rs_pc, rs_target;
  logic        rs_kill;
  logic [31:0] rs_redirect_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [31:0] PA = 32'h0040_0100;
  localparam logic [31:0] PB = 32'h0041_0100;
  localparam logic [31:0] PC = 32'h0000_2204;
  localparam logic [31:0] T1 = 32'h0000_8000;
  localparam logic [31:0] T2 = 32'h0000_9a40;
  localparam logic [31:0] T3 = 32'h0012_3450;

  always #(PERIOD/2) clk = ~clk;

  branch_target_buffer uut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_is_branch(rs_is_branch),
    .rs_taken(rs_taken), .rs_target(rs_target),
    .rs_kill(rs_kill), .rs_redirect_pc(rs_redirect_pc)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc,
                      input logic hit, input logic [31:0] nxt);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check(req, "lk_hit", {31'b0, lk_hit}, {31'b0, hit});
    check(req, "lk_taken", {31'b0, lk_taken}, {31'b0, hit});
    check(req, "lk_next_pc", lk_next_pc, nxt);
  endtask

  task automatic resolve(input string req, input logic v, input logic [31:0] pc,
                         input logic br, input logic tk, input logic [31:0] tgt,
                         input logic kill, input logic [31:0] red);
    @(negedge clk);
    rs_valid = v; rs_pc = pc; rs_is_branch = br; rs_taken = tk; rs_target = tgt;
    #1;
    check(req, "rs_kill", {31'b0, rs_kill}, {31'b0, kill});
    if (kill) check(req, "rs_redirect_pc", rs_redirect_pc, red);
    @(posedge clk);
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic t_reset();
    look("R1", PA, 1'b0, PA + 4);
    look("R1", PC, 1'b0, PC + 4);
  endtask

  task automatic t_quiet_misses();
    resolve("R4", 1'b1, PA, 1'b0, 1'b1, T1, 1'b0, 32'h0);
    look("R4", PA, 1'b0, PA + 4);
    resolve("R4", 1'b1, PA, 1'b1, 1'b0, T1, 1'b0, 32'h0);
    look("R4", PA, 1'b0, PA + 4);
    resolve("R10", 1'b0, PA, 1'b1, 1'b1, T1, 1'b0, 32'h0);
    look("R10", PA, 1'b0, PA + 4);
  endtask

  task automatic t_alloc();
    resolve("R3", 1'b1, PA, 1'b1, 1'b1, T1, 1'b1, T1);
    look("R3", PA, 1'b1, T1);
    look("R2", PA + 3, 1'b1, T1);
    look("R2", PA + 4, 1'b0, PA + 8);
  endtask

  task automatic t_confirm();
    resolve("R5", 1'b1, PA, 1'b1, 1'b1, T1, 1'b0, 32'h0);
    look("R5", PA, 1'b1, T1);
  endtask

  task automatic t_retarget();
    resolve("R7", 1'b1, PA, 1'b1, 1'b1, T2, 1'b1, T2);
    look("R7", PA, 1'b1, T2);
  endtask

  task automatic t_delete();
    resolve("R6", 1'b1, PA, 1'b1, 1'b0, T2, 1'b1, PA + 4);
    look("R6", PA, 1'b0, PA + 4);
    resolve("R6", 1'b1, PA, 1'b1, 1'b1, T1, 1'b1, T1);
    resolve("R6", 1'b1, PA, 1'b0, 1'b0, T1, 1'b1, PA + 4);
    look("R6", PA, 1'b0, PA + 4);
  endtask

  task automatic t_alias();
    resolve("R8", 1'b1, PA, 1'b1, 1'b1, T1, 1'b1, T1);
    look("R8", PB, 1'b0, PB + 4);
    resolve("R8", 1'b1, PB, 1'b1, 1'b1, T3, 1'b1, T3);
    look("R8", PB, 1'b1, T3);
    look("R8", PA, 1'b0, PA + 4);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    lk_pc = PC;
    rs_valid = 1'b1; rs_pc = PC; rs_is_branch = 1'b1; rs_taken = 1'b1; rs_target = T2;
    #1;
    check("R9", "old lk_hit", {31'b0, lk_hit}, 32'h0);
    check("R9", "old lk_next_pc", lk_next_pc, PC + 4);
    @(posedge clk);
    @(negedge clk);
    rs_valid = 1'b0;
    #1;
    check("R9", "new lk_hit", {31'b0, lk_hit}, 32'h1);
    check("R9", "new lk_next_pc", lk_next_pc, T2);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_pc = 32'h0; rs_valid = 1'b0; rs_pc = 32'h0;
    rs_is_branch = 1'b0; rs_taken = 1'b0; rs_target = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_quiet_misses();
    t_alloc();
    t_confirm();
    t_retarget();
    t_delete();
    t_alias();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule